// File: doc/BRIEF.md
# Console Hardware Page Address Decoder

This block sits between a CPU core and the memories and peripherals of a small games console. It takes one byte access at a time in a 21-bit physical address space and sorts it into one of several targets: cartridge ROM, an 8 KB work RAM that is mirrored across a 32 KB window, a 2 KB backup RAM that can be switched off and locked, and a fixed hardware page. Inside the hardware page it raises a select or write strobe for the video controller, the colour encoder, the sound generator, the timer, the joypad port or the interrupt controller. The peripherals themselves sit outside the block. Each one connects only through strobes, a shared address and write-data bus, and its own read-data input.

A single registered byte, the open-bus latch, models the console's data bus. Most hardware-page writes load it. Write-only and unmapped I/O ports return it when read. Timer-value and interrupt-status reads merge the live field with the upper bits of the latch and store the result back into it. Joypad and interrupt-mask reads reload the latch.

The CPU side is a valid/ready request channel. The requester raises `acc_valid` with the address, direction and write data. It must hold all of them unchanged until it samples `acc_ready` high at a rising clock edge. The access completes in that cycle. Every strobe and every latch update happens only in the completing cycle. Read data is valid in the same cycle. Colour-encoder accesses hold `acc_ready` low for exactly one cycle. Every other access completes in the cycle it is presented.

Top module: `io_page_decoder`

## Requirements
- R1: A read below 0x0FFFFF completes with `rom_sel` high, `rom_addr` equal to the address modulo `ROM_BYTES`, and returns `rom_rdata`. Address 0x0FFFFF itself reads 0xFF. A write below 0x100000 raises no strobe and leaves the latch unchanged.
- R2: An access in 0x1F0000–0x1F7FFF raises `ram_sel` and presents `ram_addr` equal to address bits 12:0. A write also raises `ram_we`. A read returns `ram_rdata`.
- R3: An access in 0x1EE000–0x1EE7FF reaches the backup RAM only when `bram_enable` is 1 and `bram_lock` is 0. In that case it raises `bram_sel` (and `bram_we` for a write), presents address bits 10:0 and returns `bram_rdata`. Otherwise a read returns 0xFF and a write raises nothing. `bram_dirty` rises after the first accepted write and stays high until reset.
- R4: At most one select or write strobe is high in any cycle. Addresses 0x1FE000–0x1FE3FF raise `vdc_sel`, 0x1FE400–0x1FE7FF raise `vce_sel`, and a write to 0x1FE800–0x1FEBFF raises `psg_we`. `io_we` gives the direction. Video and colour reads return their read-data inputs.
- R5: A colour-encoder access keeps `acc_ready` low in the first cycle it is presented and raises it in the second. `vce_sel` is high only in that second cycle.
- R6: Any access other than a colour-encoder access completes in the cycle it is presented. With `acc_valid` low, no strobe rises and the latch holds.
- R7: A sound-generator write loads the latch with the write data. A sound-generator read returns the latch.
- R8: A read in 0x1FEC00–0x1FEFFF returns {latch bit 7, `tmr_value`[6:0]} and stores that value into the latch.
- R9: A write to 0x1FEC00 raises `tmr_reload_we` and a write to 0x1FEC01 raises `tmr_en_we`. Both also load the latch. A write elsewhere in 0x1FEC02–0x1FEFFF raises nothing and leaves the latch unchanged.
- R10: A read in 0x1FF000–0x1FF3FF returns `pad_in` and loads it into the latch. A write there raises `pad_we` and loads the latch.
- R11: Reads of 0x1FF400 and 0x1FF401 return the latch, and writes there change nothing. 0x1FF402 reads `irq_mask` into the latch, and a write there raises `irq_mask_we` and loads the latch. A read of 0x1FF403 returns {latch bits 7:3, `irq_status`[2:0]} and stores that value. A write there raises `irq_ack` and loads the latch.
- R12: Reset clears the latch to 0x00. Any other read returns 0xFF, for example 0x1F8000–0x1FDFFF, 0x1FF404 and above, or 0x100000–0x1EDFFF. Any other write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 21 | Physical byte address |
| acc_wdata | input | 8 | Write data |
| acc_ready | output | 1 | Access completes this cycle |
| acc_rdata | output | 8 | Read data, valid in the completing cycle |
| rom_sel | output | 1 | ROM read strobe |
| rom_addr | output | ROM_AW | ROM byte index (address modulo ROM_BYTES) |
| rom_rdata | input | 8 | ROM read data |
| ram_sel | output | 1 | Work RAM select |
| ram_we | output | 1 | Work RAM write strobe |
| ram_addr | output | 13 | Work RAM index |
| ram_rdata | input | 8 | Work RAM read data |
| bram_enable | input | 1 | Backup RAM enabled |
| bram_lock | input | 1 | Backup RAM locked |
| bram_sel | output | 1 | Backup RAM select |
| bram_we | output | 1 | Backup RAM write strobe |
| bram_addr | output | 11 | Backup RAM index |
| bram_rdata | input | 8 | Backup RAM read data |
| bram_dirty | output | 1 | Backup RAM written since reset |
| io_addr | output | 10 | Low address bits for peripherals |
| io_wdata | output | 8 | Write data for peripherals |
| io_we | output | 1 | Completing access is a write |
| vdc_sel | output | 1 | Video controller select |
| vdc_rdata | input | 8 | Video controller read data |
| vce_sel | output | 1 | Colour encoder select |
| vce_rdata | input | 8 | Colour encoder read data |
| psg_we | output | 1 | Sound generator write strobe |
| tmr_reload_we | output | 1 | Timer reload write strobe |
| tmr_en_we | output | 1 | Timer enable write strobe |
| tmr_value | input | 7 | Current timer count |
| pad_in | input | 8 | Joypad input byte |
| pad_we | output | 1 | Joypad output write strobe |
| irq_mask | input | 8 | Interrupt mask byte |
| irq_mask_we | output | 1 | Interrupt mask write strobe |
| irq_status | input | 3 | Interrupt pending bits |
| irq_ack | output | 1 | Timer interrupt acknowledge strobe |

## Verification
The embedded properties watch the structural rules on every cycle:
- no two targets are ever selected together;
- ROM never sees a write;
- backup RAM is never selected while disabled or locked, and its dirty flag never falls;
- a colour-encoder select always follows a stalled cycle, and every other access completes at once;
- the latch moves only on a completing access, and a timer read stores exactly the merged value.

Only the directed scenarios can show the data values. These are:
- the address windows and their mirroring;
- the ROM wrap for a length that is not a power of two;
- the 0xFF results for unmapped and gated reads;
- the exact contents of the latch after each kind of write, reload and merge.

// File: rtl/iopd_pkg.sv
package iopd_pkg;

  localparam int ADDR_W = 21;
  localparam int DATA_W = 8;

  // Region tags produced by the address decoder
  typedef enum logic [3:0] {
    RG_NONE,
    RG_ROM,
    RG_RAM,
    RG_BRAM,
    RG_VDC,
    RG_VCE,
    RG_PSG,
    RG_TMR,
    RG_PAD,
    RG_BUFRD,
    RG_IMASK,
    RG_ISTAT
  } region_e;

  // Memory map boundaries (exclusive upper limits unless named _LAST)
  localparam logic [ADDR_W-1:0] ROM_LIMIT  = 21'h0F_FFFF;
  localparam logic [ADDR_W-1:0] BRAM_BASE  = 21'h1E_E000;
  localparam logic [ADDR_W-1:0] BRAM_LAST  = 21'h1E_E7FF;
  localparam logic [ADDR_W-1:0] RAM_BASE   = 21'h1F_0000;
  localparam logic [ADDR_W-1:0] RAM_LIMIT  = 21'h1F_8000;
  localparam logic [ADDR_W-1:0] HW_BASE    = 21'h1F_E000;
  localparam logic [ADDR_W-1:0] VCE_BASE   = 21'h1F_E400;
  localparam logic [ADDR_W-1:0] PSG_BASE   = 21'h1F_E800;
  localparam logic [ADDR_W-1:0] TMR_BASE   = 21'h1F_EC00;
  localparam logic [ADDR_W-1:0] PAD_BASE   = 21'h1F_F000;
  localparam logic [ADDR_W-1:0] IRQ_BASE   = 21'h1F_F400;

endpackage

// File: rtl/iopd_region_dec.sv
module iopd_region_dec
  import iopd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              tmr_lo_hit,
  output logic              tmr_hi_hit
);

  // Range compares in priority order; the hardware page is last.
  always_comb begin
    region = RG_NONE;
    if (addr < ROM_LIMIT) begin
      region = RG_ROM;
    end else if (addr >= BRAM_BASE && addr <= BRAM_LAST) begin
      region = RG_BRAM;
    end else if (addr >= RAM_BASE && addr < RAM_LIMIT) begin
      region = RG_RAM;
    end else if (addr >= HW_BASE) begin
      if (addr < VCE_BASE)                    region = RG_VDC;
      else if (addr < PSG_BASE)               region = RG_VCE;
      else if (addr < TMR_BASE)               region = RG_PSG;
      else if (addr < PAD_BASE)               region = RG_TMR;
      else if (addr < IRQ_BASE)               region = RG_PAD;
      else if (addr == IRQ_BASE ||
               addr == IRQ_BASE + 21'd1)      region = RG_BUFRD;
      else if (addr == IRQ_BASE + 21'd2)      region = RG_IMASK;
      else if (addr == IRQ_BASE + 21'd3)      region = RG_ISTAT;
      else                                    region = RG_NONE;
    end
  end

  assign tmr_lo_hit = (addr == TMR_BASE);
  assign tmr_hi_hit = (addr == TMR_BASE + 21'd1);

endmodule

// File: rtl/iopd_rom_index.sv
module iopd_rom_index
  import iopd_pkg::*;
#(
  parameter int ROM_BYTES = 32'h6_0000,
  parameter int ROM_AW    = $clog2(ROM_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROM_AW-1:0] index
);

  localparam bit IS_POW2 = ((ROM_BYTES & (ROM_BYTES - 1)) == 0);

  generate
    if (IS_POW2) begin : g_mask
      // Power-of-two length: wrapping is a plain bit slice.
      assign index = addr[ROM_AW-1:0];
    end else begin : g_mod
      // Other lengths: constant-divisor remainder.
      localparam logic [ADDR_W-1:0] LEN = ADDR_W'(ROM_BYTES);
      logic [ADDR_W-1:0] rem;
      assign rem   = addr % LEN;
      assign index = rem[ROM_AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/iopd_wait_gen.sv
module iopd_wait_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic need_wait,
  output logic ready
);

  logic waited_q;

  // One stall cycle for any access that needs it; cleared on completion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) waited_q <= 1'b0;
    else        waited_q <= acc_valid && need_wait && !waited_q;
  end

  assign ready = !need_wait || waited_q;

  // R6: accesses without a wait requirement never stall
  p_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !need_wait) |-> ready);

  // R5: a stalled cycle is always followed by a ready cycle while held
  p_one_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !ready) |=> (ready || !acc_valid));

endmodule

// File: rtl/iopd_iobuf.sv
module iopd_iobuf
  import iopd_pkg::*;
#(
  parameter int TMR_W = 7,
  parameter int IRQ_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              write,
  input  region_e           region,
  input  logic              tmr_lo_hit,
  input  logic              tmr_hi_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TMR_W-1:0]  tmr_value,
  input  logic [DATA_W-1:0] pad_in,
  input  logic [DATA_W-1:0] irq_mask,
  input  logic [IRQ_W-1:0]  irq_status,
  output logic [DATA_W-1:0] buf_q,
  output logic [DATA_W-1:0] tmr_merge,
  output logic [DATA_W-1:0] irq_merge
);

  logic [DATA_W-1:0] buf_d;
  logic              wr_loads;

  assign tmr_merge = {buf_q[DATA_W-1:TMR_W], tmr_value};
  assign irq_merge = {buf_q[DATA_W-1:IRQ_W], irq_status};

  always_comb begin
    case (region)
      RG_PSG, RG_PAD, RG_IMASK, RG_ISTAT: wr_loads = 1'b1;
      RG_TMR:                             wr_loads = tmr_lo_hit || tmr_hi_hit;
      default:                            wr_loads = 1'b0;
    endcase
  end

  always_comb begin
    buf_d = buf_q;
    if (fire) begin
      if (write) begin
        if (wr_loads) buf_d = wdata;
      end else begin
        case (region)
          RG_TMR:   buf_d = tmr_merge;
          RG_PAD:   buf_d = pad_in;
          RG_IMASK: buf_d = irq_mask;
          RG_ISTAT: buf_d = irq_merge;
          default:  buf_d = buf_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end

  // R12: the latch only moves on a completing access
  p_buf_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fire) |-> $stable(buf_q));

  // R8: a timer read stores the live count under the old top bit
  p_tmr_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !write && region == RG_TMR) |=>
      (buf_q[TMR_W-1:0] == $past(tmr_value)) &&
      (buf_q[DATA_W-1] == $past(buf_q[DATA_W-1])));

endmodule

// File: rtl/iopd_rdmux.sv
module iopd_rdmux
  import iopd_pkg::*;
(
  input  region_e           region,
  input  logic              bram_ok,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] bram_rdata,
  input  logic [DATA_W-1:0] vdc_rdata,
  input  logic [DATA_W-1:0] vce_rdata,
  input  logic [DATA_W-1:0] buf_q,
  input  logic [DATA_W-1:0] tmr_merge,
  input  logic [DATA_W-1:0] irq_merge,
  input  logic [DATA_W-1:0] pad_in,
  input  logic [DATA_W-1:0] irq_mask,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] FLOAT = '1;

  always_comb begin
    case (region)
      RG_ROM:   rdata = rom_rdata;
      RG_RAM:   rdata = ram_rdata;
      RG_BRAM:  rdata = bram_ok ? bram_rdata : FLOAT;
      RG_VDC:   rdata = vdc_rdata;
      RG_VCE:   rdata = vce_rdata;
      RG_PSG:   rdata = buf_q;
      RG_TMR:   rdata = tmr_merge;
      RG_PAD:   rdata = pad_in;
      RG_BUFRD: rdata = buf_q;
      RG_IMASK: rdata = irq_mask;
      RG_ISTAT: rdata = irq_merge;
      default:  rdata = FLOAT;
    endcase
  end

endmodule

// File: rtl/io_page_decoder.sv
module io_page_decoder
  import iopd_pkg::*;
#(
  parameter int ROM_BYTES = 32'h6_0000,
  parameter int ROM_AW    = $clog2(ROM_BYTES),
  parameter int RAM_AW    = 13,
  parameter int BRAM_AW   = 11,
  parameter int IO_AW     = 10,
  parameter int TMR_W     = 7,
  parameter int IRQ_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [20:0]        acc_addr,
  input  logic [7:0]         acc_wdata,
  output logic               acc_ready,
  output logic [7:0]         acc_rdata,
  output logic               rom_sel,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [7:0]         rom_rdata,
  output logic               ram_sel,
  output logic               ram_we,
  output logic [RAM_AW-1:0]  ram_addr,
  input  logic [7:0]         ram_rdata,
  input  logic               bram_enable,
  input  logic               bram_lock,
  output logic               bram_sel,
  output logic               bram_we,
  output logic [BRAM_AW-1:0] bram_addr,
  input  logic [7:0]         bram_rdata,
  output logic               bram_dirty,
  output logic [IO_AW-1:0]   io_addr,
  output logic [7:0]         io_wdata,
  output logic               io_we,
  output logic               vdc_sel,
  input  logic [7:0]         vdc_rdata,
  output logic               vce_sel,
  input  logic [7:0]         vce_rdata,
  output logic               psg_we,
  output logic               tmr_reload_we,
  output logic               tmr_en_we,
  input  logic [TMR_W-1:0]   tmr_value,
  input  logic [7:0]         pad_in,
  output logic               pad_we,
  input  logic [7:0]         irq_mask,
  output logic               irq_mask_we,
  input  logic [IRQ_W-1:0]   irq_status,
  output logic               irq_ack
);

  region_e           region;
  logic              tmr_lo_hit, tmr_hi_hit;
  logic              fire, rd_fire, wr_fire;
  logic              bram_ok;
  logic [DATA_W-1:0] buf_q, tmr_merge, irq_merge;
  logic              dirty_q;

  iopd_region_dec u_dec (
    .addr       (acc_addr),
    .region     (region),
    .tmr_lo_hit (tmr_lo_hit),
    .tmr_hi_hit (tmr_hi_hit)
  );

  iopd_rom_index #(.ROM_BYTES(ROM_BYTES), .ROM_AW(ROM_AW)) u_rom_idx (
    .addr  (acc_addr),
    .index (rom_addr)
  );

  iopd_wait_gen u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .need_wait (region == RG_VCE),
    .ready     (acc_ready)
  );

  assign fire    = acc_valid && acc_ready;
  assign rd_fire = fire && !acc_write;
  assign wr_fire = fire && acc_write;
  assign bram_ok = bram_enable && !bram_lock;

  iopd_iobuf #(.TMR_W(TMR_W), .IRQ_W(IRQ_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .write      (acc_write),
    .region     (region),
    .tmr_lo_hit (tmr_lo_hit),
    .tmr_hi_hit (tmr_hi_hit),
    .wdata      (acc_wdata),
    .tmr_value  (tmr_value),
    .pad_in     (pad_in),
    .irq_mask   (irq_mask),
    .irq_status (irq_status),
    .buf_q      (buf_q),
    .tmr_merge  (tmr_merge),
    .irq_merge  (irq_merge)
  );

  iopd_rdmux u_mux (
    .region     (region),
    .bram_ok    (bram_ok),
    .rom_rdata  (rom_rdata),
    .ram_rdata  (ram_rdata),
    .bram_rdata (bram_rdata),
    .vdc_rdata  (vdc_rdata),
    .vce_rdata  (vce_rdata),
    .buf_q      (buf_q),
    .tmr_merge  (tmr_merge),
    .irq_merge  (irq_merge),
    .pad_in     (pad_in),
    .irq_mask   (irq_mask),
    .rdata      (acc_rdata)
  );

  // Memory strobes and indices
  assign rom_sel   = rd_fire && region == RG_ROM;
  assign ram_sel   = fire && region == RG_RAM;
  assign ram_we    = ram_sel && acc_write;
  assign ram_addr  = acc_addr[RAM_AW-1:0];
  assign bram_sel  = fire && region == RG_BRAM && bram_ok;
  assign bram_we   = bram_sel && acc_write;
  assign bram_addr = acc_addr[BRAM_AW-1:0];

  // Peripheral strobes
  assign io_addr       = acc_addr[IO_AW-1:0];
  assign io_wdata      = acc_wdata;
  assign io_we         = wr_fire;
  assign vdc_sel       = fire && region == RG_VDC;
  assign vce_sel       = fire && region == RG_VCE;
  assign psg_we        = wr_fire && region == RG_PSG;
  assign tmr_reload_we = wr_fire && region == RG_TMR && tmr_lo_hit;
  assign tmr_en_we     = wr_fire && region == RG_TMR && tmr_hi_hit;
  assign pad_we        = wr_fire && region == RG_PAD;
  assign irq_mask_we   = wr_fire && region == RG_IMASK;
  assign irq_ack       = wr_fire && region == RG_ISTAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dirty_q <= 1'b0;
    else if (bram_we) dirty_q <= 1'b1;
  end
  assign bram_dirty = dirty_q;

  // R4: never more than one target strobed
  p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel, bram_sel, vdc_sel, vce_sel, psg_we,
              tmr_reload_we, tmr_en_we, pad_we, irq_mask_we, irq_ack}));

  // R1: ROM is read-only through this path
  p_rom_read_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> !acc_write);

  // R3: gated backup RAM is never reached
  p_bram_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bram_sel |-> (bram_enable && !bram_lock));

  // R3: modified flag is sticky and follows an accepted write
  p_dirty_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bram_dirty) || $past(bram_we)) |-> bram_dirty);

  // R5: colour-encoder select only after a stalled cycle
  p_vce_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vce_sel |-> $past(acc_valid && !acc_ready));

endmodule

// File: tb/io_page_decoder_tb_top.sv
`timescale 1ns/1ps
module io_page_decoder_tb_top;

  localparam int ROM_BYTES = 32'h6_0000;
  localparam int ROM_AW    = $clog2(ROM_BYTES);

  // strobe vector bit masks
  localparam logic [12:0] S_NONE = 13'h0000;
  localparam logic [12:0] S_ROM  = 13'h1000;
  localparam logic [12:0] S_RAM  = 13'h0800;
  localparam logic [12:0] S_RAMW = 13'h0C00;
  localparam logic [12:0] S_BRM  = 13'h0200;
  localparam logic [12:0] S_BRMW = 13'h0300;
  localparam logic [12:0] S_VDC  = 13'h0080;
  localparam logic [12:0] S_VCE  = 13'h0040;
  localparam logic [12:0] S_PSG  = 13'h0020;
  localparam logic [12:0] S_TRL  = 13'h0010;
  localparam logic [12:0] S_TEN  = 13'h0008;
  localparam logic [12:0] S_PAD  = 13'h0004;
  localparam logic [12:0] S_IMK  = 13'h0002;
  localparam logic [12:0] S_ACK  = 13'h0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              acc_valid = 1'b0, acc_write = 1'b0;
  logic [20:0]       acc_addr = '0;
  logic [7:0]        acc_wdata = '0;
  logic              acc_ready;
  logic [7:0]        acc_rdata;
  logic              rom_sel, ram_sel, ram_we, bram_sel, bram_we, bram_dirty;
  logic [ROM_AW-1:0] rom_addr;
  logic [12:0]       ram_addr;
  logic [10:0]       bram_addr;
  logic [7:0]        rom_rdata, ram_rdata, bram_rdata;
  logic              bram_enable = 1'b0, bram_lock = 1'b0;
  logic [9:0]        io_addr;
  logic [7:0]        io_wdata;
  logic              io_we, vdc_sel, vce_sel, psg_we, tmr_reload_we, tmr_en_we;
  logic              pad_we, irq_mask_we, irq_ack;
  logic [6:0]        tmr_value = '0;
  logic [7:0]        pad_in = '0, irq_mask = '0;
  logic [2:0]        irq_status = '0;
  logic [7:0]        vdc_rdata = 8'hD1, vce_rdata = 8'hC3;

  assign rom_rdata  = rom_addr[7:0] ^ 8'h5A;
  assign ram_rdata  = ~ram_addr[7:0];
  assign bram_rdata = bram_addr[7:0] ^ 8'h33;

  io_page_decoder #(.ROM_BYTES(ROM_BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ready(acc_ready),
    .acc_rdata(acc_rdata), .rom_sel(rom_sel), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .ram_sel(ram_sel), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .bram_enable(bram_enable),
    .bram_lock(bram_lock), .bram_sel(bram_sel), .bram_we(bram_we),
    .bram_addr(bram_addr), .bram_rdata(bram_rdata), .bram_dirty(bram_dirty),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_we(io_we),
    .vdc_sel(vdc_sel), .vdc_rdata(vdc_rdata), .vce_sel(vce_sel),
    .vce_rdata(vce_rdata), .psg_we(psg_we), .tmr_reload_we(tmr_reload_we),
    .tmr_en_we(tmr_en_we), .tmr_value(tmr_value), .pad_in(pad_in),
    .pad_we(pad_we), .irq_mask(irq_mask), .irq_mask_we(irq_mask_we),
    .irq_status(irq_status), .irq_ack(irq_ack)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0]  rd;
  logic [12:0] st;
  int          waits;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    waits = 0;
    #1;
    while (!acc_ready) begin
      if (vce_sel) st = 13'h1FFF;
      @(negedge clk); #1; waits++;
    end
    rd = acc_rdata;
    st = {rom_sel, ram_sel, ram_we, bram_sel, bram_we, vdc_sel, vce_sel,
          psg_we, tmr_reload_we, tmr_en_we, pad_we, irq_mask_we, irq_ack};
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic buf_is(input string req, input logic [7:0] exp);
    acc(1'b0, 21'h1F_F400, 8'h00);
    chk(req, rd, exp);
  endtask

  task automatic t_reset();
    buf_is("R12 latch after reset", 8'h00);
    chk("R3 dirty after reset", bram_dirty, 1'b0);
    @(negedge clk);
    chk("R6 idle strobes", {rom_sel, ram_sel, vdc_sel, psg_we, irq_ack}, 5'b0);
  endtask

  task automatic t_rom();
    acc(1'b0, 21'h00_0123, 8'h00);
    chk("R1 rom data", rd, 8'h23 ^ 8'h5A);
    chk("R1 rom strobe", st, S_ROM);
    chk("R6 rom no wait", waits, 0);
    acc(1'b0, 21'h07_0010, 8'h00);
    chk("R1 rom wrap index", rom_addr, 19'h1_0010);
    acc(1'b0, 21'h0F_FFFF, 8'h00);
    chk("R1 top rom address floats", rd, 8'hFF);
    acc(1'b1, 21'h1F_E800, 8'h6B);
    acc(1'b1, 21'h00_0010, 8'h99);
    chk("R1 rom write no strobe", st, S_NONE);
    buf_is("R1 rom write keeps latch", 8'h6B);
  endtask

  task automatic t_ram();
    acc(1'b0, 21'h1F_2345, 8'h00);
    chk("R2 ram mirror index", rd, 8'hBA);
    chk("R2 ram read strobe", st, S_RAM);
    acc(1'b1, 21'h1F_7FFF, 8'h12);
    chk("R2 ram write strobe", st, S_RAMW);
    chk("R2 ram write index", ram_addr, 13'h1FFF);
  endtask

  task automatic t_bram();
    bram_enable = 1'b0; bram_lock = 1'b0;
    acc(1'b0, 21'h1E_E010, 8'h00);
    chk("R3 disabled read", rd, 8'hFF);
    acc(1'b1, 21'h1E_E010, 8'h44);
    chk("R3 disabled write dropped", st, S_NONE);
    bram_enable = 1'b1; bram_lock = 1'b1;
    acc(1'b1, 21'h1E_E010, 8'h44);
    chk("R3 locked write dropped", st, S_NONE);
    chk("R3 dirty after dropped", bram_dirty, 1'b0);
    bram_lock = 1'b0;
    acc(1'b0, 21'h1E_E010, 8'h00);
    chk("R3 open read", rd, 8'h23);
    acc(1'b1, 21'h1E_E7FF, 8'h44);
    chk("R3 open write strobe", st, S_BRMW);
    chk("R3 index", bram_addr, 11'h7FF);
    @(negedge clk);
    chk("R3 dirty set", bram_dirty, 1'b1);
    bram_enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 dirty sticky", bram_dirty, 1'b1);
  endtask

  task automatic t_video();
    acc(1'b0, 21'h1F_E005, 8'h00);
    chk("R4 vdc read", rd, 8'hD1);
    chk("R4 vdc strobe", st, S_VDC);
    acc(1'b0, 21'h1F_E401, 8'h00);
    chk("R5 vce read wait", waits, 1);
    chk("R5 vce strobe", st, S_VCE);
    chk("R4 vce data", rd, 8'hC3);
    acc(1'b1, 21'h1F_E7FF, 8'h0F);
    chk("R5 vce write wait", waits, 1);
    chk("R4 vce write dir", st, S_VCE);
  endtask

  task automatic t_psg();
    acc(1'b1, 21'h1F_E800, 8'h9C);
    chk("R7 psg strobe", st, S_PSG);
    buf_is("R7 psg write loads latch", 8'h9C);
    acc(1'b0, 21'h1F_E900, 8'h00);
    chk("R7 psg read returns latch", rd, 8'h9C);
  endtask

  task automatic t_timer();
    acc(1'b1, 21'h1F_E800, 8'h80);
    tmr_value = 7'h15;
    acc(1'b0, 21'h1F_EC05, 8'h00);
    chk("R8 timer read merge high", rd, 8'h95);
    buf_is("R8 timer read stored", 8'h95);
    acc(1'b1, 21'h1F_E800, 8'h00);
    acc(1'b0, 21'h1F_EFFF, 8'h00);
    chk("R8 timer read merge low", rd, 8'h15);
    acc(1'b1, 21'h1F_EC00, 8'h3A);
    chk("R9 reload strobe", st, S_TRL);
    buf_is("R9 reload loads latch", 8'h3A);
    acc(1'b1, 21'h1F_EC01, 8'h01);
    chk("R9 enable strobe", st, S_TEN);
    acc(1'b1, 21'h1F_EC02, 8'h77);
    chk("R9 other timer write", st, S_NONE);
    buf_is("R9 other timer write keeps latch", 8'h01);
  endtask

  task automatic t_pad();
    pad_in = 8'h4E;
    acc(1'b0, 21'h1F_F100, 8'h00);
    chk("R10 pad read", rd, 8'h4E);
    buf_is("R10 pad read loads latch", 8'h4E);
    acc(1'b1, 21'h1F_F000, 8'h03);
    chk("R10 pad write strobe", st, S_PAD);
    buf_is("R10 pad write loads latch", 8'h03);
  endtask

  task automatic t_irq();
    irq_mask = 8'h05;
    acc(1'b0, 21'h1F_F402, 8'h00);
    chk("R11 mask read", rd, 8'h05);
    buf_is("R11 mask read loads latch", 8'h05);
    acc(1'b1, 21'h1F_F402, 8'h06);
    chk("R11 mask write strobe", st, S_IMK);
    acc(1'b1, 21'h1F_E800, 8'hF8);
    irq_status = 3'b101;
    acc(1'b0, 21'h1F_F403, 8'h00);
    chk("R11 status merge", rd, 8'hFD);
    acc(1'b0, 21'h1F_F401, 8'h00);
    chk("R11 status stored, 401 reads latch", rd, 8'hFD);
    acc(1'b1, 21'h1F_F403, 8'h2C);
    chk("R11 ack strobe", st, S_ACK);
    acc(1'b1, 21'h1F_F401, 8'h11);
    chk("R11 401 write no strobe", st, S_NONE);
    buf_is("R11 401 write keeps latch", 8'h2C);
  endtask

  task automatic t_unmapped();
    acc(1'b0, 21'h1F_9000, 8'h00);
    chk("R12 gap read", rd, 8'hFF);
    acc(1'b0, 21'h1F_F404, 8'h00);
    chk("R12 high page read", rd, 8'hFF);
    acc(1'b0, 21'h1F_F800, 8'h00);
    chk("R12 disc area read", rd, 8'hFF);
    acc(1'b0, 21'h15_0000, 8'h00);
    chk("R12 mid space read", rd, 8'hFF);
    acc(1'b1, 21'h1F_A000, 8'h55);
    chk("R12 unmapped write no strobe", st, S_NONE);
    buf_is("R12 unmapped write keeps latch", 8'h2C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rom();
    t_ram();
    t_bram();
    t_video();
    t_psg();
    t_timer();
    t_pad();
    t_irq();
    t_unmapped();
    done = 1;
  end

  initial begin
    wait (done || cyc >= 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule